// File: doc/BRIEF.md
# Blind IQ Imbalance and DC Offset Corrector

This block sits at the tail of a zero-IF receive path. It takes pairs of signed in-phase and quadrature samples, qualified by a valid strobe, and returns corrected pairs with their own valid strobe. Each rail first passes through its own leaky DC tracker, and the tracked value is subtracted from the sample. This acts as a notch at zero frequency, which is sound as long as the wanted signal carries no DC of its own.

The quadrature rail is then corrected in two steps. A phase coefficient removes the part of Q that leaks in from I, and a gain coefficient rescales what remains. Both coefficients adapt blindly, with no pilot or training tone. The phase loop drives the mean of I·Q' to zero. The gain loop drives the mean of I² − Q''² to zero.

Each loop has its own enable and step shift. A synchronous clear returns all estimates to their start values. All four estimates can be read back continuously.

Top module: `iqbal_corrector`

## Requirements
- R1: After reset, `out_valid` is 0, `gain_est` reads 16384 (1.0 in unsigned Q2.14), and `phase_est`, `dc_i_est` and `dc_q_est` read 0.
- R2: `out_valid` equals `in_valid` delayed by exactly 3 clock cycles, whatever the enables and shifts are, and samples leave in arrival order.
- R3: Each rail keeps a 34-bit signed accumulator A whose value is the DC estimate scaled by 2^16. On each valid sample with `dc_en` high, A becomes A + ((x·2^16 − A) >>> `dc_shift`), where the shift is meant to lie in 4..20. The corrected sample is x − (A >>> 16), saturated to 16 bits, using A from before the update. The estimate port shows A >>> 16.
- R4: With p = the top 16 bits of a 32-bit signed phase accumulator (Q1.15), Q' = sat16(Qdc − ((p·Idc) >>> 15)).
- R5: With g = the top 16 bits of a 32-bit unsigned gain accumulator (unsigned Q2.14), `out_q` = sat16((g·Q') >>> 14), and `out_i` is the DC-corrected I.
- R6: With `phase_en` high, each sample adds (Idc·Q') >>> `phase_shift` to the phase accumulator. The sum saturates to the signed 32-bit range.
- R7: With `gain_en` high, each sample adds (Idc² − Q''²) >>> `gain_shift` to the gain accumulator. The sum clamps to [0, 2^32 − 1].
- R8: When a loop's enable is low, its estimate holds its value, and correction goes on using that held value.
- R9: A `coef_clr` pulse returns every estimate to its reset value on the next edge. It does not disturb the sample stream.
- R10: Both output rails saturate to the range −32768..32767.
- R11: A complex tone with a DC offset on each rail, a 10% Q gain error and a 3° phase skew is corrected. After convergence, the output mean on each rail, the mean of I² − Q² and the mean of I·Q all fall below small thresholds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| coef_clr | input | 1 | Synchronous clear of all estimates |
| dc_en | input | 1 | DC tracking enable |
| gain_en | input | 1 | Gain loop enable |
| phase_en | input | 1 | Phase loop enable |
| dc_shift | input | 5 | DC tracker step shift |
| gain_shift | input | 5 | Gain loop step shift |
| phase_shift | input | 5 | Phase loop step shift |
| in_valid | input | 1 | Input pair valid |
| in_i | input | 16 | In-phase sample, signed |
| in_q | input | 16 | Quadrature sample, signed |
| out_valid | output | 1 | Output pair valid |
| out_i | output | 16 | Corrected in-phase sample, signed |
| out_q | output | 16 | Corrected quadrature sample, signed |
| dc_i_est | output | 16 | I-rail DC estimate, signed |
| dc_q_est | output | 16 | Q-rail DC estimate, signed |
| gain_est | output | 16 | Gain coefficient, unsigned Q2.14 |
| phase_est | output | 16 | Phase coefficient, signed Q1.15 |

## Verification
The hold and clear properties assume two things about the inputs. First, `coef_clr` is used only as a pulse. Second, an estimate is judged frozen only in a cycle where its enable is low and no clear is pending. The stimulus therefore changes enables, shifts and the clear only while the three pipeline stages are empty, which it ensures by inserting idle cycles first. The stimulus also keeps `dc_shift` inside 4..20. The tone used for convergence has a period of 16 samples, and statistics are taken over a whole number of periods, so that the tone itself adds nothing to the measured means.

// File: rtl/iqc_pkg.sv
package iqc_pkg;

  // clamp a wide signed value into a w-bit signed range
  function automatic logic signed [63:0] sat_s(input logic signed [63:0] v, input int w);
    logic signed [63:0] hi;
    logic signed [63:0] lo;
    hi = (64'sd1 <<< (w - 1)) - 64'sd1;
    lo = -hi - 64'sd1;
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

  // clamp a wide signed value into a w-bit unsigned range
  function automatic logic signed [63:0] clamp_u(input logic signed [63:0] v, input int w);
    logic signed [63:0] hi;
    hi = (64'sd1 <<< w) - 64'sd1;
    if (v < 0) return 64'sd0;
    if (v > hi) return hi;
    return v;
  endfunction

endpackage

// File: rtl/iqc_dc_track.sv
module iqc_dc_track #(
  parameter int W  = 16,
  parameter int SW = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                en,
  input  logic                vld,
  input  logic [SW-1:0]       k,
  input  logic signed [W-1:0] x,
  output logic signed [W-1:0] y,
  output logic signed [W-1:0] est
);
  import iqc_pkg::*;

  localparam int AW = 2 * W + 2;

  logic signed [AW-1:0] acc_q, acc_d;
  logic signed [AW-1:0] x_sc;

  assign x_sc = AW'(x) <<< W;
  assign est  = acc_q[2*W-1:W];

  always_comb begin
    acc_d = acc_q;
    if (clr)
      acc_d = '0;
    else if (vld && en)
      acc_d = acc_q + ((x_sc - acc_q) >>> k);
  end

  always_comb begin
    y = W'(sat_s(64'(x) - 64'(est), W));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      acc_q <= '0;
    else
      acc_q <= acc_d;
  end

endmodule

// File: rtl/iqc_phase_fix.sv
module iqc_phase_fix #(
  parameter int W  = 16,
  parameter int CW = 32,
  parameter int SW = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                en,
  input  logic                vld,
  input  logic [SW-1:0]       mu,
  input  logic signed [W-1:0] i_in,
  input  logic signed [W-1:0] q_in,
  output logic signed [W-1:0] q_out,
  output logic signed [W-1:0] coef
);
  import iqc_pkg::*;

  localparam int PF = W - 1;

  logic signed [CW-1:0] acc_q, acc_d;
  logic signed [63:0]   leak;
  logic signed [63:0]   step;

  assign coef = acc_q[CW-1 -: W];

  always_comb begin
    leak  = (64'(i_in) * 64'(coef)) >>> PF;
    q_out = W'(sat_s(64'(q_in) - leak, W));
    step  = (64'(i_in) * 64'(q_out)) >>> mu;
  end

  always_comb begin
    acc_d = acc_q;
    if (clr)
      acc_d = '0;
    else if (vld && en)
      acc_d = CW'(sat_s(64'(acc_q) + step, CW));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      acc_q <= '0;
    else
      acc_q <= acc_d;
  end

endmodule

// File: rtl/iqc_gain_fix.sv
module iqc_gain_fix #(
  parameter int W  = 16,
  parameter int CW = 32,
  parameter int SW = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                en,
  input  logic                vld,
  input  logic [SW-1:0]       mu,
  input  logic signed [W-1:0] i_in,
  input  logic signed [W-1:0] q_in,
  output logic signed [W-1:0] q_out,
  output logic [W-1:0]        coef
);
  import iqc_pkg::*;

  localparam int GF = W - 2;
  localparam logic [CW-1:0] ONE = CW'(1) << (GF + CW - W);

  logic [CW-1:0]      acc_q, acc_d;
  logic signed [63:0] err;

  assign coef = acc_q[CW-1 -: W];

  always_comb begin
    q_out = W'(sat_s((64'($signed({1'b0, coef})) * 64'(q_in)) >>> GF, W));
    err   = 64'(i_in) * 64'(i_in) - 64'(q_out) * 64'(q_out);
  end

  always_comb begin
    acc_d = acc_q;
    if (clr)
      acc_d = ONE;
    else if (vld && en)
      acc_d = CW'(clamp_u($signed({{(64 - CW){1'b0}}, acc_q}) + (err >>> mu), CW));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      acc_q <= ONE;
    else
      acc_q <= acc_d;
  end

endmodule

// File: rtl/iqbal_corrector.sv
module iqbal_corrector #(
  parameter int W  = 16,
  parameter int CW = 32,
  parameter int SW = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                coef_clr,
  input  logic                dc_en,
  input  logic                gain_en,
  input  logic                phase_en,
  input  logic [SW-1:0]       dc_shift,
  input  logic [SW-1:0]       gain_shift,
  input  logic [SW-1:0]       phase_shift,
  input  logic                in_valid,
  input  logic signed [W-1:0] in_i,
  input  logic signed [W-1:0] in_q,
  output logic                out_valid,
  output logic signed [W-1:0] out_i,
  output logic signed [W-1:0] out_q,
  output logic signed [W-1:0] dc_i_est,
  output logic signed [W-1:0] dc_q_est,
  output logic [W-1:0]        gain_est,
  output logic signed [W-1:0] phase_est
);

  localparam int RAILS = 2;

  logic signed [W-1:0] rail_x [RAILS];
  logic signed [W-1:0] rail_y [RAILS];
  logic signed [W-1:0] rail_e [RAILS];

  assign rail_x[0] = in_i;
  assign rail_x[1] = in_q;

  for (genvar r = 0; r < RAILS; r++) begin : g_dc
    iqc_dc_track #(.W(W), .SW(SW)) u_dc (
      .clk (clk),
      .rst_n (rst_n),
      .clr (coef_clr),
      .en (dc_en),
      .vld (in_valid),
      .k (dc_shift),
      .x (rail_x[r]),
      .y (rail_y[r]),
      .est (rail_e[r])
    );
  end

  assign dc_i_est = rail_e[0];
  assign dc_q_est = rail_e[1];

  // stage 1: DC-corrected pair
  logic                s1_v, s1_v_d;
  logic signed [W-1:0] s1_i, s1_q, s1_i_d, s1_q_d;
  // stage 2: phase-corrected pair
  logic                s2_v, s2_v_d;
  logic signed [W-1:0] s2_i, s2_q, s2_i_d, s2_q_d;
  logic signed [W-1:0] ph_q;
  // stage 3: output
  logic                o_v_d;
  logic signed [W-1:0] o_i_d, o_q_d;
  logic signed [W-1:0] gn_q;

  iqc_phase_fix #(.W(W), .CW(CW), .SW(SW)) u_phase (
    .clk (clk),
    .rst_n (rst_n),
    .clr (coef_clr),
    .en (phase_en),
    .vld (s1_v),
    .mu (phase_shift),
    .i_in (s1_i),
    .q_in (s1_q),
    .q_out (ph_q),
    .coef (phase_est)
  );

  iqc_gain_fix #(.W(W), .CW(CW), .SW(SW)) u_gain (
    .clk (clk),
    .rst_n (rst_n),
    .clr (coef_clr),
    .en (gain_en),
    .vld (s2_v),
    .mu (gain_shift),
    .i_in (s2_i),
    .q_in (s2_q),
    .q_out (gn_q),
    .coef (gain_est)
  );

  always_comb begin
    s1_v_d = in_valid;
    s1_i_d = s1_i;
    s1_q_d = s1_q;
    if (in_valid) begin
      s1_i_d = rail_y[0];
      s1_q_d = rail_y[1];
    end
    s2_v_d = s1_v;
    s2_i_d = s2_i;
    s2_q_d = s2_q;
    if (s1_v) begin
      s2_i_d = s1_i;
      s2_q_d = ph_q;
    end
    o_v_d = s2_v;
    o_i_d = out_i;
    o_q_d = out_q;
    if (s2_v) begin
      o_i_d = s2_i;
      o_q_d = gn_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v      <= 1'b0;
      s1_i      <= '0;
      s1_q      <= '0;
      s2_v      <= 1'b0;
      s2_i      <= '0;
      s2_q      <= '0;
      out_valid <= 1'b0;
      out_i     <= '0;
      out_q     <= '0;
    end else begin
      s1_v      <= s1_v_d;
      s1_i      <= s1_i_d;
      s1_q      <= s1_q_d;
      s2_v      <= s2_v_d;
      s2_i      <= s2_i_d;
      s2_q      <= s2_q_d;
      out_valid <= o_v_d;
      out_i     <= o_i_d;
      out_q     <= o_q_d;
    end
  end

endmodule

// File: rtl/iqbal_corrector_chk.sv
module iqbal_corrector_chk #(
  parameter int W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                coef_clr,
  input logic                dc_en,
  input logic                gain_en,
  input logic                phase_en,
  input logic                in_valid,
  input logic                out_valid,
  input logic signed [W-1:0] dc_i_est,
  input logic signed [W-1:0] dc_q_est,
  input logic [W-1:0]        gain_est,
  input logic signed [W-1:0] phase_est
);

  localparam logic [W-1:0] G_ONE = W'(1) << (W - 2);

  logic [2:0] vhist;
  logic [1:0] since_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vhist     <= '0;
      since_rst <= '0;
    end else begin
      vhist <= {vhist[1:0], in_valid};
      if (since_rst != 2'd3)
        since_rst <= since_rst + 2'd1;
    end
  end

  // R2: three-cycle valid latency
  a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd3) |-> (out_valid == vhist[2]));

  // R8: frozen loops hold their estimates
  a_r8_dc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!dc_en && !coef_clr) |=> ($stable(dc_i_est) && $stable(dc_q_est)));

  a_r8_gain_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!gain_en && !coef_clr) |=> $stable(gain_est));

  a_r8_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!phase_en && !coef_clr) |=> $stable(phase_est));

  // R9: clear restores start values
  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    coef_clr |=> (gain_est == G_ONE && phase_est == '0 && dc_i_est == '0 && dc_q_est == '0));

endmodule

bind iqbal_corrector iqbal_corrector_chk #(.W(W)) u_chk (
  .clk (clk),
  .rst_n (rst_n),
  .coef_clr (coef_clr),
  .dc_en (dc_en),
  .gain_en (gain_en),
  .phase_en (phase_en),
  .in_valid (in_valid),
  .out_valid (out_valid),
  .dc_i_est (dc_i_est),
  .dc_q_est (dc_q_est),
  .gain_est (gain_est),
  .phase_est (phase_est)
);

// File: tb/iqbal_corrector_tb.sv
`timescale 1ns/1ps
module iqbal_corrector_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic coef_clr = 1'b0;
  logic dc_en = 1'b0, gain_en = 1'b0, phase_en = 1'b0;
  logic [4:0] dc_shift = 5'd8, gain_shift = 5'd10, phase_shift = 5'd10;
  logic in_valid = 1'b0;
  logic signed [15:0] in_i = '0, in_q = '0;
  logic out_valid;
  logic signed [15:0] out_i, out_q, dc_i_est, dc_q_est, phase_est;
  logic [15:0] gain_est;

  always #2.5 clk = ~clk;

  iqbal_corrector u_dut (
    .clk(clk), .rst_n(rst_n), .coef_clr(coef_clr),
    .dc_en(dc_en), .gain_en(gain_en), .phase_en(phase_en),
    .dc_shift(dc_shift), .gain_shift(gain_shift), .phase_shift(phase_shift),
    .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
    .out_valid(out_valid), .out_i(out_i), .out_q(out_q),
    .dc_i_est(dc_i_est), .dc_q_est(dc_q_est),
    .gain_est(gain_est), .phase_est(phase_est)
  );

  int tests = 0;
  int fails = 0;

  // reference state
  longint m_dc [2];
  longint m_p;
  longint m_g;
  logic   pend_clr = 1'b0;

  // expected-output delay line
  logic   dv [3];
  longint di [3];
  longint dq [3];
  int     didx [3];
  int     sidx = 0;
  int     stat_from = 32'h7fffffff;
  longint last_oq = 0;

  real s_i = 0.0, s_q = 0.0, s_ii = 0.0, s_qq = 0.0, s_iq = 0.0;
  int  s_n = 0;

  function automatic longint sat(input longint v, input int w);
    longint hi;
    hi = (64'sd1 <<< (w - 1)) - 1;
    if (v > hi) return hi;
    if (v < -hi - 1) return -hi - 1;
    return v;
  endfunction

  task automatic model_reset();
    m_dc[0] = 0;
    m_dc[1] = 0;
    m_p = 0;
    m_g = 64'sd1 <<< 30;
  endtask

  task automatic model(input int xi, input int xq, output longint oi, output longint oq);
    longint ci, cq, pc, qp, gc, qpp, x [2], c [2];
    x[0] = xi;
    x[1] = xq;
    for (int r = 0; r < 2; r++) begin
      c[r] = sat(x[r] - (m_dc[r] >>> 16), 16);
      if (dc_en) m_dc[r] = m_dc[r] + (((x[r] <<< 16) - m_dc[r]) >>> dc_shift);
    end
    ci = c[0];
    cq = c[1];
    pc = m_p >>> 16;
    qp = sat(cq - ((ci * pc) >>> 15), 16);
    if (phase_en) m_p = sat(m_p + ((ci * qp) >>> phase_shift), 32);
    gc = m_g >>> 16;
    qpp = sat((gc * qp) >>> 14, 16);
    if (gain_en) begin
      m_g = m_g + ((ci * ci - qpp * qpp) >>> gain_shift);
      if (m_g < 0) m_g = 0;
      if (m_g > 64'sd4294967295) m_g = 64'sd4294967295;
    end
    oi = ci;
    oq = qpp;
  endtask

  task automatic step(input logic v, input int xi, input int xq);
    @(negedge clk);
    tests++;
    if (out_valid !== dv[2]) begin
      fails++;
      $display("FAIL R2 out_valid act=%0d exp=%0d", out_valid, dv[2]);
    end else if (dv[2]) begin
      tests++;
      if (longint'(out_i) != di[2] || longint'(out_q) != dq[2]) begin
        fails++;
        $display("FAIL R3 R4 R5 R6 R7 sample %0d act=(%0d,%0d) exp=(%0d,%0d)",
                 didx[2], out_i, out_q, di[2], dq[2]);
      end
      last_oq = longint'(out_q);
      if (didx[2] >= stat_from) begin
        s_i += real'(out_i);
        s_q += real'(out_q);
        s_ii += real'(out_i) * real'(out_i);
        s_qq += real'(out_q) * real'(out_q);
        s_iq += real'(out_i) * real'(out_q);
        s_n++;
      end
    end
    for (int s = 2; s > 0; s--) begin
      dv[s] = dv[s-1];
      di[s] = di[s-1];
      dq[s] = dq[s-1];
      didx[s] = didx[s-1];
    end
    coef_clr = pend_clr;
    if (pend_clr) model_reset();
    pend_clr = 1'b0;
    in_valid = v;
    in_i = 16'(xi);
    in_q = 16'(xq);
    dv[0] = v;
    didx[0] = sidx;
    if (v) begin
      model(xi, xq, di[0], dq[0]);
      sidx++;
    end
  endtask

  task automatic idle(input int n);
    for (int c = 0; c < n; c++) step(1'b0, 0, 0);
  endtask

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_est(input string tag);
    chk(longint'(dc_i_est) == (m_dc[0] >>> 16), {tag, " dc_i_est"}, dc_i_est, m_dc[0] >>> 16);
    chk(longint'(dc_q_est) == (m_dc[1] >>> 16), {tag, " dc_q_est"}, dc_q_est, m_dc[1] >>> 16);
    chk(longint'(gain_est) == (m_g >>> 16), {tag, " gain_est"}, gain_est, m_g >>> 16);
    chk(longint'(phase_est) == (m_p >>> 16), {tag, " phase_est"}, phase_est, m_p >>> 16);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired act=%0d exp=%0d", 1, 0);
    finish_run();
  end

  initial begin
    longint g0, p0, d0, d1;
    real ang, a, mi, mq, pw, dp, xp;
    for (int s = 0; s < 3; s++) begin
      dv[s] = 1'b0; di[s] = 0; dq[s] = 0; didx[s] = 0;
    end
    model_reset();
    repeat (4) @(negedge clk);
    // R1: reset values
    chk(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
    chk(gain_est == 16'd16384, "R1 gain_est", gain_est, 16384);
    chk(phase_est == 16'sd0, "R1 phase_est", phase_est, 0);
    chk(dc_i_est == 16'sd0 && dc_q_est == 16'sd0, "R1 dc est", dc_i_est, 0);
    rst_n = 1'b1;
    idle(3);

    // R2 R3 R4 R5 R6 R7: random stream with gaps, all loops on
    dc_en = 1'b1; gain_en = 1'b1; phase_en = 1'b1;
    dc_shift = 5'd5; gain_shift = 5'd12; phase_shift = 5'd12;
    for (int n = 0; n < 400; n++)
      step(($urandom % 4) != 0, int'($signed(16'($urandom))), int'($signed(16'($urandom))));
    idle(4);
    chk_est("R3 R6 R7 random");

    // R8: freeze all loops, correction continues with held values
    dc_en = 1'b0; gain_en = 1'b0; phase_en = 1'b0;
    idle(1);
    g0 = longint'(gain_est); p0 = longint'(phase_est);
    d0 = longint'(dc_i_est); d1 = longint'(dc_q_est);
    for (int n = 0; n < 100; n++)
      step(1'b1, int'($signed(16'($urandom))), int'($signed(16'($urandom))));
    idle(4);
    chk(longint'(gain_est) == g0, "R8 gain frozen", gain_est, g0);
    chk(longint'(phase_est) == p0, "R8 phase frozen", phase_est, p0);
    chk(longint'(dc_i_est) == d0 && longint'(dc_q_est) == d1, "R8 dc frozen", dc_i_est, d0);

    // R9: clear
    pend_clr = 1'b1;
    idle(2);
    chk(gain_est == 16'd16384, "R9 gain cleared", gain_est, 16384);
    chk(phase_est == 16'sd0, "R9 phase cleared", phase_est, 0);
    chk(dc_i_est == 16'sd0 && dc_q_est == 16'sd0, "R9 dc cleared", dc_i_est, 0);

    // R7 clamp then R10 saturation
    gain_en = 1'b1; gain_shift = 5'd0;
    idle(1);
    for (int n = 0; n < 12; n++) step(1'b1, 20000, 100);
    idle(4);
    gain_en = 1'b0;
    idle(1);
    chk(gain_est == 16'hFFFF, "R7 gain clamp", gain_est, 65535);
    chk_est("R7 after clamp");
    step(1'b1, 0, 30000);
    idle(3);
    chk(last_oq == 32767, "R10 positive saturation", last_oq, 32767);
    step(1'b1, 0, -30000);
    idle(3);
    chk(last_oq == -32768, "R10 negative saturation", last_oq, -32768);
    idle(2);

    // R11: convergence on an impaired complex tone
    pend_clr = 1'b1;
    idle(2);
    dc_shift = 5'd10; gain_shift = 5'd6; phase_shift = 5'd4;
    dc_en = 1'b1; gain_en = 1'b1; phase_en = 1'b1;
    idle(1);
    sidx = 0;
    stat_from = 12000 - 1024;
    a = 8000.0;
    for (int n = 0; n < 12000; n++) begin
      ang = 2.0 * 3.14159265358979 * real'(n % 16) / 16.0;
      step(1'b1, int'(a * $cos(ang)) + 600,
           int'(1.1 * a * $sin(ang + 3.0 * 3.14159265358979 / 180.0)) - 400);
    end
    idle(4);
    chk_est("R11 final estimates");
    chk(s_n == 1024, "R11 sample count", s_n, 1024);
    mi = s_i / real'(s_n); mq = s_q / real'(s_n);
    pw = s_ii / real'(s_n);
    dp = (s_ii - s_qq) / real'(s_n);
    xp = s_iq / real'(s_n);
    chk(mi < 40.0 && mi > -40.0, "R11 residual I DC", longint'(mi), 0);
    chk(mq < 40.0 && mq > -40.0, "R11 residual Q DC", longint'(mq), 0);
    chk(dp < 0.01 * pw && dp > -0.01 * pw, "R11 power difference", longint'(dp), 0);
    chk(xp < 0.01 * pw && xp > -0.01 * pw, "R11 cross product", longint'(xp), 0);
    finish_run();
  end

endmodule